// File: doc/BRIEF.md
# Edge-Pulse Link Codec

This block is a cycle-level digital model of a transition-signalling link across a contactless channel. The transmit half watches a single data bit and, whenever that bit changes, emits one signed pulse symbol on a three-level channel. The pulse is positive for a rising bit and negative for a falling bit, and it lasts a parameterised number of clock cycles. Between pulses the channel sits idle, so a steady bit costs no channel activity.

The receive half turns signed pulses back into a level. It holds the last polarity it decoded, in the way a set/reset latch does. A compile-time parameter selects the receive variant. In the clocked variant, the receiver only looks at the channel while an evaluate-phase input is high. While that input is low (the precharge phase), it keeps its output. In the clockless variant, the receiver takes every pulse without regard to any phase input, and its output changes only when a pulse of the opposite polarity arrives.

The transmit output and the receive input are separate ports. An integrator may wire them together for a loopback, or route them across a modelled channel.

Top module: `edge_pulse_codec`

## Requirements
- R1: While reset is high, and after it is released with the data input held at 0, the channel output is idle (2'b00), the recovered output is 0 and the error flag is 0. No pulse is produced.
- R2: If the data input is 1 at a clock edge and the previously registered bit is 0, the channel output carries the positive code 2'b01 from that edge for exactly PULSE_CYC cycles.
- R3: If the data input is 0 at a clock edge and the previously registered bit is 1, the channel output carries the negative code 2'b10 from that edge for exactly PULSE_CYC cycles.
- R4: Once a pulse has run its PULSE_CYC cycles with no further data change, the channel output returns to idle 2'b00. The transmitter never emits 2'b11.
- R5: A data change that arrives while a pulse is still running restarts the pulse with the new polarity and a full PULSE_CYC length.
- R6: In the clocked variant, with the evaluate input high at an edge, a channel code of 2'b01 makes the recovered output 1 and a code of 2'b10 makes it 0, starting from that edge.
- R7: In the clocked variant, with the evaluate input low at an edge, the channel input is ignored and the recovered output keeps its value.
- R8: In the clockless variant, polarity pulses update the recovered output at every edge, whatever the level of the evaluate input.
- R9: An idle code, or a pulse whose polarity matches the current recovered output, leaves the recovered output unchanged.
- R10: A channel code of 2'b11 at an edge sets the error flag from that edge for one cycle and leaves the recovered output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit_i | input | 1 | Data bit to be sent as transitions |
| chan_o | output | 2 | Transmit symbol: 00 idle, 01 positive, 10 negative |
| chan_i | input | 2 | Received symbol, same encoding; 11 is illegal |
| eval_i | input | 1 | Evaluate phase (high) or precharge phase (low); ignored in the clockless variant |
| rx_bit_o | output | 1 | Recovered data level |
| sym_err_o | output | 1 | Illegal symbol seen at the previous edge |

## Verification
Every output is registered. A change on the data input therefore appears on the channel output after the first rising edge that samples it, and stays there for PULSE_CYC edges. A channel symbol affects the recovered output and the error flag after the single edge that samples it. The bench drives its inputs at the falling edge. It advances a behavioural model of pulse countdown and held polarity at each rising edge, and it compares both receive variants and the transmitter against that model at the next falling edge. Each comparison therefore sees exactly one register stage of delay.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [1:0] {
    SYM_IDLE = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BAD  = 2'b11
  } sym_e;

endpackage

// File: rtl/epc_sym_decode.sv
module epc_sym_decode
  import epc_pkg::*;
(
  input  logic [1:0] sym_i,
  output logic       is_pos_o,
  output logic       is_neg_o,
  output logic       is_bad_o
);

  always_comb begin
    is_pos_o = 1'b0;
    is_neg_o = 1'b0;
    is_bad_o = 1'b0;
    case (sym_e'(sym_i))
      SYM_POS: is_pos_o = 1'b1;
      SYM_NEG: is_neg_o = 1'b1;
      SYM_BAD: is_bad_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/epc_tx.sv
module epc_tx
  import epc_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_i,
  output logic [1:0] sym_o
);

  localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic          prev_q;
  sym_e          sym_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      sym_q  <= SYM_IDLE;
      left_q <= '0;
    end else if (bit_i != prev_q) begin
      prev_q <= bit_i;
      sym_q  <= bit_i ? SYM_POS : SYM_NEG;
      left_q <= LAST;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      sym_q  <= SYM_IDLE;
    end
  end

  assign sym_o = sym_q;

  p_rise_pos_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_i && !prev_q) |=> (sym_o == 2'b01));

  p_fall_neg_r3: assert property (@(posedge clk) disable iff (rst)
    (!bit_i && prev_q) |=> (sym_o == 2'b10));

  p_legal_sym_r4: assert property (@(posedge clk) disable iff (rst)
    sym_o != 2'b11);

  p_steady_prev_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_i == prev_q) |=> $stable(prev_q));

endmodule

// File: rtl/epc_rx.sv
module epc_rx
  import epc_pkg::*;
#(
  parameter bit CLOCKLESS = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sym_i,
  input  logic       eval_i,
  output logic       bit_o,
  output logic       err_o
);

  logic is_pos, is_neg, is_bad;
  logic take;
  logic bit_q, err_q;

  epc_sym_decode u_dec (
    .sym_i   (sym_i),
    .is_pos_o(is_pos),
    .is_neg_o(is_neg),
    .is_bad_o(is_bad)
  );

  generate
    if (CLOCKLESS) begin : g_clockless
      assign take = 1'b1;
    end else begin : g_clocked
      assign take = eval_i;
    end
  endgenerate

  // polarity-holding latch: set on positive, reset on negative
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= is_bad;
      if (take && is_pos)      bit_q <= 1'b1;
      else if (take && is_neg) bit_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;
  assign err_o = err_q;

  p_pos_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (sym_i == 2'b01 && (eval_i || CLOCKLESS)) |=> bit_o);

  p_precharge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!CLOCKLESS && !eval_i) |=> $stable(bit_o));

  p_same_pol_r9: assert property (@(posedge clk) disable iff (rst)
    (sym_i == 2'b10 && !bit_o) |=> !bit_o);

  p_bad_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (sym_i == 2'b11) |=> (err_o && $stable(bit_o)));

endmodule

// File: rtl/edge_pulse_codec.sv
module edge_pulse_codec
  import epc_pkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter bit CLOCKLESS = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_bit_i,
  output logic [1:0] chan_o,
  input  logic [1:0] chan_i,
  input  logic       eval_i,
  output logic       rx_bit_o,
  output logic       sym_err_o
);

  epc_tx #(.PULSE_CYC(PULSE_CYC)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .bit_i(tx_bit_i),
    .sym_o(chan_o)
  );

  epc_rx #(.CLOCKLESS(CLOCKLESS)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .sym_i (chan_i),
    .eval_i(eval_i),
    .bit_o (rx_bit_o),
    .err_o (sym_err_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (chan_o == 2'b00 && !rx_bit_o && !sym_err_o));

endmodule

// File: tb/edge_pulse_codec_tb_top.sv
module edge_pulse_codec_tb_top;

  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_bit = 1'b0;
  logic [1:0] chan_in = 2'b00;
  logic eval = 1'b0;

  logic [1:0] chan_a, chan_b;
  logic rx_a, rx_b, err_a, err_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit       m_prev;
  int       m_left;
  logic [1:0] m_sym;
  bit       m_rx [2];
  bit       m_err;

  always #2 clk = ~clk;

  edge_pulse_codec #(.PULSE_CYC(PW), .CLOCKLESS(1'b0)) dut_i (
    .clk(clk), .rst(rst), .tx_bit_i(tx_bit), .chan_o(chan_a),
    .chan_i(chan_in), .eval_i(eval), .rx_bit_o(rx_a), .sym_err_o(err_a)
  );

  edge_pulse_codec #(.PULSE_CYC(PW), .CLOCKLESS(1'b1)) dut_cl_i (
    .clk(clk), .rst(rst), .tx_bit_i(tx_bit), .chan_o(chan_b),
    .chan_i(chan_in), .eval_i(eval), .rx_bit_o(rx_b), .sym_err_o(err_b)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_prev = 0; m_left = 0; m_sym = 2'b00;
      m_rx[0] = 0; m_rx[1] = 0; m_err = 0;
    end else begin
      if (tx_bit != m_prev) begin
        m_prev = tx_bit;
        m_sym  = tx_bit ? 2'b01 : 2'b10;
        m_left = PW;
      end else if (m_left > 0) begin
        m_left--;
      end
      m_err = (chan_in == 2'b11);
      for (int m = 0; m < 2; m++) begin
        if (m == 1 || eval) begin
          if (chan_in == 2'b01) m_rx[m] = 1;
          else if (chan_in == 2'b10) m_rx[m] = 0;
        end
      end
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, "chan clocked", chan_a, (m_left > 0) ? m_sym : 2'b00);
    chk(req, "chan clockless", chan_b, (m_left > 0) ? m_sym : 2'b00);
    chk(req, "rx clocked", {1'b0, rx_a}, {1'b0, m_rx[0]});
    chk(req, "rx clockless", {1'b0, rx_b}, {1'b0, m_rx[1]});
    chk(req, "err clocked", {1'b0, err_a}, {1'b0, m_err});
    chk(req, "err clockless", {1'b0, err_b}, {1'b0, m_err});
  endtask

  initial begin
    // R1: reset state and quiet release
    for (int i = 0; i < 3; i++) step("R1");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step("R1");
    // R2 rising pulse, then R4 return to idle
    tx_bit = 1'b1;
    for (int i = 0; i < 3; i++) step("R2");
    for (int i = 0; i < 3; i++) step("R4");
    // R3 falling pulse
    tx_bit = 1'b0;
    for (int i = 0; i < 3; i++) step("R3");
    for (int i = 0; i < 2; i++) step("R4");
    // R5 edge during a pulse restarts it
    tx_bit = 1'b1;
    step("R5");
    tx_bit = 1'b0;
    for (int i = 0; i < 4; i++) step("R5");
    step("R4");
    // receiver
    eval = 1'b1; chan_in = 2'b01; step("R6");
    chan_in = 2'b00; step("R9");
    chan_in = 2'b01; step("R9");
    eval = 1'b0; chan_in = 2'b10; step("R7 R8");
    chan_in = 2'b00; eval = 1'b1; step("R7");
    chan_in = 2'b10; step("R6");
    chan_in = 2'b10; step("R9");
    chan_in = 2'b11; step("R10");
    chan_in = 2'b00; step("R10");
    eval = 1'b0; chan_in = 2'b01; step("R8");
    chan_in = 2'b11; step("R10");
    chan_in = 2'b00; step("R8");
    summary();
  end

endmodule